// File: doc/BRIEF.md
# Transmit FIFO Threshold Gating Controller

This block decides when a transmit FIFO may be refilled and when it may be emptied. A bus-master fetch engine fills the FIFO from system memory, and a MAC transmit engine drains it onto the wire. The controller tells the fetch engine that a fragment read may be requested once the FIFO has enough free room. It tells the transmit engine that a frame may begin once enough bytes are buffered or a whole packet is already present. It also turns a 3-bit burst code into a burst length in 32-bit words.

Three settings are held in a captured configuration: a burst code, a fill threshold and a drain threshold. Both thresholds count in 32-byte units. The controller checks that these settings agree with each other. Inconsistent settings raise an error flag and block both permissions. The configuration inputs are captured only while the transmit engine reports that it is idle. All outputs are registered. The FIFO storage and the bus protocol lie outside this block.

Top module: `tx_fifo_gate`

## Requirements
- R1: `burst_words` gives the decoded burst length in 32-bit words. Code 0 decodes to 128. A code k from 1 to 7 decodes to 2^(k-1), so codes 1 to 7 give 1, 2, 4, 8, 16, 32 and 64.
- R2: `fetch_ok` is 1 exactly when `cfg_err` is 0 and the free space reaches the fill threshold, that is, free space >= fill_thr*32 bytes. Free space is `fifo_size - fifo_used`, and it counts as 0 when `fifo_used` exceeds `fifo_size`.
- R3: `tx_start_ok` is 1 exactly when `cfg_err` is 0 and at least one of two conditions holds: `fifo_used` >= drain_thr*32, or `pkt_complete` is 1.
- R4: A fill threshold of 0 or a drain threshold of 0 sets `cfg_err`.
- R5: `cfg_err` is set when (fill_thr + drain_thr)*32 is greater than 2016 bytes. A sum of exactly 2016 is legal.
- R6: `cfg_err` is set when the burst length in bytes (`burst_words`*4) is greater than fill_thr*32. Equality is legal.
- R7: While `cfg_err` is 1, both `fetch_ok` and `tx_start_ok` are 0.
- R8: The configuration inputs are captured only on clock edges where `tx_idle` is 1. Changes made while `tx_idle` is 0 have no effect on any output.
- R9: All outputs are registered. Occupancy and `pkt_complete` changes appear one clock edge after they are sampled. A captured configuration shows on the outputs at the edge after its capture edge.
- R10: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_idle | input | 1 | Transmit engine idle; enables configuration capture |
| cfg_burst_code | input | 3 | Maximum burst-size code |
| cfg_fill_thr | input | 6 | Fill threshold in 32-byte units |
| cfg_drain_thr | input | 6 | Drain threshold in 32-byte units |
| fifo_used | input | 12 | Bytes currently held in the FIFO |
| fifo_size | input | 12 | FIFO capacity in bytes |
| pkt_complete | input | 1 | At least one complete packet is in the FIFO |
| burst_words | output | 8 | Decoded burst length in 32-bit words |
| fetch_ok | output | 1 | Fragment-read request permitted |
| tx_start_ok | output | 1 | Transmit start permitted |
| cfg_err | output | 1 | Captured configuration is inconsistent |

## Verification
Random configurations are mixed legal and illegal, with occupancies swept across the whole FIFO. Together they separate the three error causes from one another and from the gating comparisons. Directed cases sit exactly on each boundary: a free space equal to the fill threshold, a buffered count one byte below the drain threshold, a threshold sum of exactly 2016, a burst equal to the fill threshold, and occupancy above capacity. These cases tell `>=` apart from `>` and show that free space clamps at zero. Setting `pkt_complete` with an empty FIFO separates the packet path from the level path. Driving garbage onto the configuration inputs while `tx_idle` is low shows that capture ignores inputs outside the idle window.

// File: rtl/tfg_pkg.sv
// Package: shared field widths and the captured configuration type
// for the transmit FIFO gating controller.
package tfg_pkg;
    localparam int CODE_W     = 3;   // burst code width
    localparam int THR_W      = 6;   // threshold field width
    localparam int UNIT_SHIFT = 5;   // thresholds count 32-byte units
    localparam int WORD_SHIFT = 2;   // a word is 4 bytes

    typedef struct packed {
        logic [CODE_W-1:0] burst_code;
        logic [THR_W-1:0]  fill_thr;
        logic [THR_W-1:0]  drain_thr;
    } tfg_cfg_t;
endpackage

// File: rtl/tfg_cfg_reg.sv
// Module: tfg_cfg_reg
// Holds the configuration word. The word is replaced only on edges
// where load is high. Assumes the caller drives load from the transmit
// engine's idle indication.
module tfg_cfg_reg
    import tfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  tfg_cfg_t cfg_in,
    output tfg_cfg_t cfg_q
);
    // Capture the configuration while idle; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/tfg_burst_decode.sv
// Module: tfg_burst_decode
// Turns the burst code into a word count. Code 0 selects the largest
// burst, 2^(codes-1). A nonzero code k selects 2^(k-1). Assumes BURST_W
// is wide enough to hold the largest burst.
module tfg_burst_decode
    import tfg_pkg::*;
#(
    parameter int BURST_W = 8
) (
    input  logic [CODE_W-1:0]  code,
    output logic [BURST_W-1:0] words
);
    localparam int NCODE = 1 << CODE_W;

    logic [BURST_W-1:0] word_tab [NCODE];

    // One table entry per code value.
    for (genvar k = 0; k < NCODE; k++) begin : g_code
        if (k == 0) begin : g_max
            assign word_tab[k] = BURST_W'(1) << (NCODE - 1);
        end else begin : g_pow
            assign word_tab[k] = BURST_W'(1) << (k - 1);
        end
    end

    assign words = word_tab[code];
endmodule

// File: rtl/tfg_cfg_check.sv
// Module: tfg_cfg_check
// Converts the thresholds to bytes and flags an inconsistent
// configuration. A configuration is bad when a threshold is zero, when
// the threshold sum exceeds SUM_LIMIT bytes, or when the burst is larger
// than the fill threshold. Purely combinational.
module tfg_cfg_check
    import tfg_pkg::*;
#(
    parameter int BURST_W   = 8,
    parameter int SUM_LIMIT = 2016,
    parameter int BYTE_W    = THR_W + UNIT_SHIFT
) (
    input  tfg_cfg_t           cfg,
    input  logic [BURST_W-1:0] words,
    output logic [BYTE_W-1:0]  fill_bytes,
    output logic [BYTE_W-1:0]  drain_bytes,
    output logic               cfg_bad
);
    localparam int BB_W  = BURST_W + WORD_SHIFT;
    localparam int CMP_W = ((BYTE_W > BB_W) ? BYTE_W : BB_W) + 1;

    logic [CMP_W-1:0] burst_bytes;
    logic [CMP_W-1:0] thr_sum;
    logic             zero_thr;
    logic             sum_over;
    logic             burst_over;

    // Scale the fields to bytes and evaluate the three error causes.
    always_comb begin
        fill_bytes  = BYTE_W'(cfg.fill_thr)  << UNIT_SHIFT;
        drain_bytes = BYTE_W'(cfg.drain_thr) << UNIT_SHIFT;
        burst_bytes = CMP_W'(words) << WORD_SHIFT;
        thr_sum     = CMP_W'(fill_bytes) + CMP_W'(drain_bytes);
        zero_thr    = (cfg.fill_thr == '0) || (cfg.drain_thr == '0);
        sum_over    = thr_sum > CMP_W'(SUM_LIMIT);
        burst_over  = burst_bytes > CMP_W'(fill_bytes);
        cfg_bad     = zero_thr || sum_over || burst_over;
    end
endmodule

// File: rtl/tfg_gate.sv
// Module: tfg_gate
// Compares the FIFO state with the byte thresholds. Free space clamps
// to zero when the occupancy exceeds the size. A bad configuration
// blocks both permissions. Purely combinational.
module tfg_gate #(
    parameter int OCC_W  = 12,
    parameter int BYTE_W = 11
) (
    input  logic [OCC_W-1:0]  fifo_used,
    input  logic [OCC_W-1:0]  fifo_size,
    input  logic              pkt_complete,
    input  logic [BYTE_W-1:0] fill_bytes,
    input  logic [BYTE_W-1:0] drain_bytes,
    input  logic              cfg_bad,
    output logic              fetch_d,
    output logic              start_d
);
    localparam int CW = ((OCC_W > BYTE_W) ? OCC_W : BYTE_W) + 1;

    logic [OCC_W-1:0] free_bytes;

    // Derive the free space and the two permissions.
    always_comb begin
        free_bytes = (fifo_used > fifo_size) ? '0 : (fifo_size - fifo_used);
        fetch_d    = !cfg_bad && (CW'(free_bytes) >= CW'(fill_bytes));
        start_d    = !cfg_bad && ((CW'(fifo_used) >= CW'(drain_bytes)) || pkt_complete);
    end
endmodule

// File: rtl/tx_fifo_gate.sv
// Module: tx_fifo_gate (top)
// Gates the fetch and drain sides of a transmit FIFO by threshold and
// checks that the configuration is consistent. The configuration is
// captured while tx_idle is high. Every output is registered, one edge
// after its inputs.
module tx_fifo_gate
    import tfg_pkg::*;
#(
    parameter int OCC_W     = 12,
    parameter int BURST_W   = 8,
    parameter int SUM_LIMIT = 2016
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_idle,
    input  logic [CODE_W-1:0]  cfg_burst_code,
    input  logic [THR_W-1:0]   cfg_fill_thr,
    input  logic [THR_W-1:0]   cfg_drain_thr,
    input  logic [OCC_W-1:0]   fifo_used,
    input  logic [OCC_W-1:0]   fifo_size,
    input  logic               pkt_complete,
    output logic [BURST_W-1:0] burst_words,
    output logic               fetch_ok,
    output logic               tx_start_ok,
    output logic               cfg_err
);
    localparam int BYTE_W = THR_W + UNIT_SHIFT;

    tfg_cfg_t           cfg_in;
    tfg_cfg_t           cfg_q;
    logic [BURST_W-1:0] words_d;
    logic [BYTE_W-1:0]  fill_bytes;
    logic [BYTE_W-1:0]  drain_bytes;
    logic               cfg_bad;
    logic               fetch_d;
    logic               start_d;

    // Pack the configuration inputs into the shared type.
    always_comb begin
        cfg_in.burst_code = cfg_burst_code;
        cfg_in.fill_thr   = cfg_fill_thr;
        cfg_in.drain_thr  = cfg_drain_thr;
    end

    tfg_cfg_reg i_cfg_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_idle),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    tfg_burst_decode #(.BURST_W(BURST_W)) i_decode (
        .code  (cfg_q.burst_code),
        .words (words_d)
    );

    tfg_cfg_check #(
        .BURST_W   (BURST_W),
        .SUM_LIMIT (SUM_LIMIT),
        .BYTE_W    (BYTE_W)
    ) i_check (
        .cfg         (cfg_q),
        .words       (words_d),
        .fill_bytes  (fill_bytes),
        .drain_bytes (drain_bytes),
        .cfg_bad     (cfg_bad)
    );

    tfg_gate #(.OCC_W(OCC_W), .BYTE_W(BYTE_W)) i_gate (
        .fifo_used    (fifo_used),
        .fifo_size    (fifo_size),
        .pkt_complete (pkt_complete),
        .fill_bytes   (fill_bytes),
        .drain_bytes  (drain_bytes),
        .cfg_bad      (cfg_bad),
        .fetch_d      (fetch_d),
        .start_d      (start_d)
    );

    // Register every output; all outputs are zero during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_words <= '0;
            fetch_ok    <= 1'b0;
            tx_start_ok <= 1'b0;
            cfg_err     <= 1'b0;
        end else begin
            burst_words <= words_d;
            fetch_ok    <= fetch_d;
            tx_start_ok <= start_d;
            cfg_err     <= cfg_bad;
        end
    end
endmodule

// File: rtl/tfg_chk.sv
// Module: tfg_chk
// Property checker for tx_fifo_gate. It watches ports only and is
// attached with the bind below.
module tfg_chk #(
    parameter int OCC_W   = 12,
    parameter int BURST_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_idle,
    input logic [OCC_W-1:0]   fifo_used,
    input logic [OCC_W-1:0]   fifo_size,
    input logic               pkt_complete,
    input logic [BURST_W-1:0] burst_words,
    input logic               fetch_ok,
    input logic               tx_start_ok,
    input logic               cfg_err
);
    logic [1:0] hist;

    // Count edges since reset, up to 3, so that $past only looks back into valid history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 2'd0;
        else if (hist != 2'd3) hist <= hist + 2'd1;
    end

    p_onehot_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hist != 2'd0) |-> ($countones(burst_words) == 1));

    p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!fetch_ok && !tx_start_ok));

    p_pkt_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hist != 2'd0) && $past(pkt_complete) && !cfg_err) |-> tx_start_ok);

    p_empty_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hist != 2'd0) && ($past(fifo_used) == '0) && !$past(pkt_complete)) |-> !tx_start_ok);

    p_full_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hist != 2'd0) && ($past(fifo_used) >= $past(fifo_size))) |-> !fetch_ok);

    p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hist == 2'd3) && !$past(tx_idle, 2)) |-> ($stable(burst_words) && $stable(cfg_err)));
endmodule

bind tx_fifo_gate tfg_chk #(.OCC_W(OCC_W), .BURST_W(BURST_W)) i_tfg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_idle      (tx_idle),
    .fifo_used    (fifo_used),
    .fifo_size    (fifo_size),
    .pkt_complete (pkt_complete),
    .burst_words  (burst_words),
    .fetch_ok     (fetch_ok),
    .tx_start_ok  (tx_start_ok),
    .cfg_err      (cfg_err)
);

// File: tb/test_tx_fifo_gate.sv
// Bench for tx_fifo_gate: directed corners plus seeded random configurations.
module test_tx_fifo_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_idle;
    logic [2:0]  cfg_burst_code;
    logic [5:0]  cfg_fill_thr;
    logic [5:0]  cfg_drain_thr;
    logic [11:0] fifo_used;
    logic [11:0] fifo_size;
    logic        pkt_complete;
    logic [7:0]  burst_words;
    logic        fetch_ok;
    logic        tx_start_ok;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_code, m_fill, m_drain;
    bit settled = 0;
    logic [7:0] prev_words;
    logic       prev_fetch, prev_start, prev_err;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    tx_fifo_gate i_tx_fifo_gate (
        .clk(clk), .rst_n(rst_n), .tx_idle(tx_idle),
        .cfg_burst_code(cfg_burst_code), .cfg_fill_thr(cfg_fill_thr),
        .cfg_drain_thr(cfg_drain_thr), .fifo_used(fifo_used),
        .fifo_size(fifo_size), .pkt_complete(pkt_complete),
        .burst_words(burst_words), .fetch_ok(fetch_ok),
        .tx_start_ok(tx_start_ok), .cfg_err(cfg_err)
    );

    function automatic int f_words(int code);
        return (code == 0) ? 128 : (1 << (code - 1));
    endfunction

    function automatic bit f_err(int code, int fill, int drain);
        return (fill == 0) || (drain == 0) || ((fill + drain) * 32 > 2016)
            || (f_words(code) * 4 > fill * 32);
    endfunction

    function automatic bit f_fetch(int code, int fill, int drain, int used, int size);
        int free_b;
        free_b = (used > size) ? 0 : size - used;
        return !f_err(code, fill, drain) && (free_b >= fill * 32);
    endfunction

    function automatic bit f_start(int code, int fill, int drain, int used, bit pkt);
        return !f_err(code, fill, drain) && ((used >= drain * 32) || pkt);
    endfunction

    task automatic expect_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Capture a configuration, then put garbage on the inputs while idle is low (R8).
    task automatic set_cfg(int code, int fill, int drain);
        cfg_burst_code = 3'(code);
        cfg_fill_thr   = 6'(fill);
        cfg_drain_thr  = 6'(drain);
        tx_idle        = 1'b1;
        @(negedge clk);
        tx_idle        = 1'b0;
        cfg_burst_code = 3'($urandom);
        cfg_fill_thr   = 6'($urandom);
        cfg_drain_thr  = 6'($urandom);
        m_code = code; m_fill = fill; m_drain = drain;
        settled = 0;
    endtask

    // Apply occupancy, confirm nothing moves before the edge (R9), then check all outputs.
    task automatic check_occ(int used, int size, bit pkt, string tag);
        fifo_used    = 12'(used);
        fifo_size    = 12'(size);
        pkt_complete = pkt;
        #1;
        if (settled) begin
            expect_eq("R9", "fetch held before edge", int'(fetch_ok), int'(prev_fetch));
            expect_eq("R9", "start held before edge", int'(tx_start_ok), int'(prev_start));
        end
        @(negedge clk);
        expect_eq({"R1 ", tag}, "burst_words", int'(burst_words), f_words(m_code));
        expect_eq({"R4 R5 R6 R8 ", tag}, "cfg_err", int'(cfg_err),
                  int'(f_err(m_code, m_fill, m_drain)));
        expect_eq({"R2 R7 ", tag}, "fetch_ok", int'(fetch_ok),
                  int'(f_fetch(m_code, m_fill, m_drain, used, size)));
        expect_eq({"R3 R7 ", tag}, "tx_start_ok", int'(tx_start_ok),
                  int'(f_start(m_code, m_fill, m_drain, used, pkt)));
        prev_words = burst_words; prev_fetch = fetch_ok;
        prev_start = tx_start_ok; prev_err = cfg_err;
        settled = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        seed_dummy = $urandom(32'd1234);
        rst_n = 1'b0; tx_idle = 1'b1;
        cfg_burst_code = 3'd3; cfg_fill_thr = 6'd8; cfg_drain_thr = 6'd8;
        fifo_used = 12'd0; fifo_size = 12'd2048; pkt_complete = 1'b1;
        repeat (3) @(negedge clk);
        expect_eq("R10", "burst_words in reset", int'(burst_words), 0);
        expect_eq("R10", "fetch_ok in reset", int'(fetch_ok), 0);
        expect_eq("R10", "tx_start_ok in reset", int'(tx_start_ok), 0);
        expect_eq("R10", "cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        tx_idle = 1'b0;

        // R1: every code, with a legal large fill threshold
        for (int c = 0; c < 8; c++) begin
            set_cfg(c, 20, 10);
            check_occ(100, 2048, 1'b0, "code sweep");
        end
        // R2 boundary: free equals the fill threshold, then one byte short
        set_cfg(2, 10, 10);
        check_occ(2048 - 320, 2048, 1'b0, "free==fill");
        check_occ(2048 - 319, 2048, 1'b0, "free==fill-1");
        check_occ(3000, 2048, 1'b0, "used>size clamps free to 0");
        // R3 boundary: used exactly at and one byte below the drain threshold; packet flag alone
        check_occ(320, 2048, 1'b0, "used==drain");
        check_occ(319, 2048, 1'b0, "used==drain-1");
        check_occ(0, 2048, 1'b1, "empty with complete packet");
        check_occ(0, 2048, 1'b0, "empty");
        // R4: zero thresholds
        set_cfg(1, 0, 5);
        check_occ(0, 2048, 1'b1, "zero fill");
        set_cfg(1, 5, 0);
        check_occ(1000, 2048, 1'b1, "zero drain");
        // R5: sum at 2016 is legal, 2048 is not
        set_cfg(1, 32, 31);
        check_occ(1000, 2048, 1'b0, "sum 2016");
        set_cfg(1, 32, 32);
        check_occ(1000, 2048, 1'b0, "sum 2048");
        // R6: a 512-byte burst against fill 16 (equal) and fill 15 (smaller)
        set_cfg(0, 16, 4);
        check_occ(200, 2048, 1'b0, "burst==fill");
        set_cfg(0, 15, 4);
        check_occ(200, 2048, 1'b0, "burst>fill");
        set_cfg(7, 8, 4);
        check_occ(200, 2048, 1'b0, "256B burst==fill");

        // Random mix of configurations and occupancies
        for (int i = 0; i < 400; i++) begin
            int code, fill, drain, size;
            code = $urandom % 8;
            if (($urandom % 2) == 0) begin
                fill  = 1 + $urandom % 40;
                drain = 1 + $urandom % (63 - fill);
            end else begin
                fill  = $urandom % 64;
                drain = $urandom % 64;
            end
            set_cfg(code, fill, drain);
            size = (($urandom % 4) == 0) ? 512 + $urandom % 3584 : 2048;
            for (int j = 0; j < 4; j++) begin
                int used;
                used = $urandom % (size + 64);
                if (used > 4095) used = 4095;
                check_occ(used, size, 1'($urandom % 3 == 0), "random");
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule